// File: doc/BRIEF.md
# Partition Network Interface with Per-Channel Sampling Buffers

This block joins one processor partition to its router. The partition reaches it through a small register window. It first writes a destination descriptor, then writes a 32-bit payload into the transmit register. The interface keeps that payload for one cycle and then offers a single flit to the router. The flit carries the destination router, the destination interface and the channel id in its header.

Only one packet can be in flight. While that packet is held or is waiting for the router, any further payload write is refused and a sticky overrun flag is raised.

In the receive direction, every channel owns one sampling buffer. An arriving packet replaces the previous contents of its channel's buffer, whatever the partition is doing at the time. Reads leave the data in place, so the partition always sees the most recent sample of each channel. A per-channel fresh flag reports whether a new sample has arrived since that channel was last read.

Top module: `sampling_net_iface`

## Requirements
- R1: After reset `tx_valid` is 0, the status word reads 0 and every channel buffer reads 0.
- R2: The destination register is at address 0, with wdata[1:0] = channel, wdata[3:2] = interface and wdata[5:4] = router. A write to address 1 while idle is captured at that clock edge and held for one cycle. `tx_valid` rises after the following edge. `tx_flit` is {router[37:36], interface[35:34], channel[33:32], payload[31:0]}, taken from the destination register.
- R3: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` and `tx_flit` stay unchanged. After an edge with both high, `tx_valid` is 0.
- R4: A write to address 1 while a packet is held or waiting is rejected: `tx_flit` is unchanged and status bit 0 (overrun) is set. A status read returns the flag and clears it, so the next status read shows bit 0 as 0.
- R5: The status word at address 2 has bit 0 = overrun, bit 1 = transmit busy (held or waiting), and bit 2+c = fresh flag of channel c.
- R6: An `rx_valid` cycle stores `rx_flit[31:0]` into the buffer of the channel in `rx_flit[33:32]`. Buffers of other channels are unaffected.
- R7: A later arrival on a channel overwrites that channel's earlier sample.
- R8: A read of address 4+c returns channel c's buffer on `host_rdata` after the read edge. Reading again without a new arrival returns the same value.
- R9: A channel's fresh flag is set by an arrival and cleared by a read of that channel. When an arrival and a read of the same channel share a cycle, the read returns the previous sample and the fresh flag stays set.
- R10: Arrivals are captured on consecutive cycles and regardless of host reads or writes in the same cycle. `host_rdata` changes only on a read, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Router accepts outgoing flit |
| tx_flit | output | 38 | Header and payload toward the router |
| rx_valid | input | 1 | Incoming packet valid |
| rx_flit | input | 34 | Incoming channel id and payload |

## Verification
On every cycle, the assertions check four things. A captured payload reaches the router exactly two edges after its write. A stalled flit stays frozen. A refused write raises overrun without touching the flit. Each arrival lands in its own channel while the other channels hold still.

Only the bench scenarios can show the following, because they depend on full sequences:
- the encoded header layout;
- the read-to-clear behaviour of overrun;
- the collision of a read with a same-channel arrival;
- that repeated reads and back-to-back arrivals give the value sequence the partition expects.

// File: rtl/sni_pkg.sv
`timescale 1ns/1ps
package sni_pkg;
    localparam int ADDR_TX_DEST = 0;
    localparam int ADDR_TX_DATA = 1;
    localparam int ADDR_STATUS  = 2;
    localparam int ADDR_RX_BASE = 4;

    localparam int STAT_OVR   = 0;
    localparam int STAT_BUSY  = 1;
    localparam int STAT_FRESH = 2;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HOLD = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;
endpackage

// File: rtl/ni_tx_path.sv
`timescale 1ns/1ps
module ni_tx_path
    import sni_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 2,
    parameter int NW = 2,
    parameter int RW = 2,
    localparam int HW = RW + NW + CW,
    localparam int FW = HW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dest_we,
    input  logic [HW-1:0] dest_wdata,
    input  logic          data_we,
    input  logic [DW-1:0] data_wdata,
    input  logic          ovr_clr,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [FW-1:0] tx_flit,
    output logic          busy,
    output logic          overrun
);
    typedef struct packed {
        tx_state_e     st;
        logic [HW-1:0] dest;
        logic [FW-1:0] flit;
        logic          ovr;
    } tx_t;

    tx_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (dest_we) begin
            s_d.dest = dest_wdata;
        end
        case (s_q.st)
            TX_IDLE: begin
                if (data_we) begin
                    s_d.flit = {s_q.dest, data_wdata};
                    s_d.st   = TX_HOLD;
                end
            end
            TX_HOLD: s_d.st = TX_SEND;
            TX_SEND: begin
                if (tx_ready) begin
                    s_d.st = TX_IDLE;
                end
            end
            default: s_d.st = TX_IDLE;
        endcase
        if (ovr_clr) begin
            s_d.ovr = 1'b0;
        end
        if (data_we && (s_q.st != TX_IDLE)) begin
            s_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: TX_IDLE, dest: '0, flit: '0, ovr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid = (s_q.st == TX_SEND);
    assign tx_flit  = s_q.flit;
    assign busy     = (s_q.st != TX_IDLE);
    assign overrun  = s_q.ovr;

    assert_forward_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(data_we && !busy, 2) |-> tx_valid);
    assert_no_early_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !busy) |=> !tx_valid);
    assert_flit_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_flit)));
    assert_drop_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_valid);
    assert_overrun_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && busy) |=> (overrun && $stable(tx_flit)));
    assert_overrun_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !(data_we && busy)) |=> !overrun);
endmodule

// File: rtl/ni_rx_store.sv
`timescale 1ns/1ps
module ni_rx_store #(
    parameter int NCH = 4,
    parameter int DW  = 32,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CW-1:0]     rx_ch,
    input  logic [DW-1:0]     rx_payload,
    input  logic [NCH-1:0]    rd_clr,
    output logic [NCH*DW-1:0] buf_flat,
    output logic [NCH-1:0]    fresh
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] data;
        logic [NCH-1:0]         fresh;
    } rx_t;

    rx_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int c = 0; c < NCH; c++) begin
            if (rd_clr[c]) begin
                s_d.fresh[c] = 1'b0;
            end
            if (rx_valid && (rx_ch == CW'(c))) begin
                s_d.data[c]  = rx_payload;
                s_d.fresh[c] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fresh = s_q.fresh;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign buf_flat[c*DW +: DW] = s_q.data[c];

        assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid && rx_ch == CW'(c)) |=> (buf_flat[c*DW +: DW] == $past(rx_payload) && fresh[c]));
        assert_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(rx_valid && rx_ch == CW'(c)) |=> $stable(buf_flat[c*DW +: DW]));
        assert_fresh_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr[c] && !(rx_valid && rx_ch == CW'(c))) |=> !fresh[c]);
    end
endmodule

// File: rtl/sampling_net_iface.sv
`timescale 1ns/1ps
module sampling_net_iface
    import sni_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 32,
    parameter int NW     = 2,
    parameter int RW     = 2,
    parameter int ADDR_W = 4,
    localparam int CW    = $clog2(NCH),
    localparam int HW    = RW + NW + CW,
    localparam int FW    = HW + DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [FW-1:0]     tx_flit,
    input  logic              rx_valid,
    input  logic [CW+DW-1:0]  rx_flit
);
    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    logic              dest_we, data_we, stat_re;
    logic              busy, overrun;
    logic [NCH-1:0]    rd_clr, fresh;
    logic [NCH*DW-1:0] buf_flat;
    logic [DW-1:0]     status_w;

    assign dest_we = host_we && (host_addr == ADDR_W'(ADDR_TX_DEST));
    assign data_we = host_we && (host_addr == ADDR_W'(ADDR_TX_DATA));
    assign stat_re = host_re && (host_addr == ADDR_W'(ADDR_STATUS));

    for (genvar c = 0; c < NCH; c++) begin : g_clr
        assign rd_clr[c] = host_re && (host_addr == ADDR_W'(ADDR_RX_BASE + c));
    end

    ni_tx_path #(.DW(DW), .CW(CW), .NW(NW), .RW(RW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .dest_we    (dest_we),
        .dest_wdata (host_wdata[HW-1:0]),
        .data_we    (data_we),
        .data_wdata (host_wdata),
        .ovr_clr    (stat_re),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_flit    (tx_flit),
        .busy       (busy),
        .overrun    (overrun)
    );

    ni_rx_store #(.NCH(NCH), .DW(DW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_ch      (rx_flit[CW+DW-1:DW]),
        .rx_payload (rx_flit[DW-1:0]),
        .rd_clr     (rd_clr),
        .buf_flat   (buf_flat),
        .fresh      (fresh)
    );

    always_comb begin
        status_w                     = '0;
        status_w[STAT_OVR]           = overrun;
        status_w[STAT_BUSY]          = busy;
        status_w[STAT_FRESH +: NCH]  = fresh;
    end

    always_comb begin
        rd_d = rd_q;
        if (host_re) begin
            rd_d.rdata = '0;
            if (stat_re) begin
                rd_d.rdata = status_w;
            end
            for (int c = 0; c < NCH; c++) begin
                if (rd_clr[c]) begin
                    rd_d.rdata = buf_flat[c*DW +: DW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign host_rdata = rd_q.rdata;

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_re |=> $stable(host_rdata));

    for (genvar c = 0; c < NCH; c++) begin : g_rd_chk
        assert_read_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rd_clr[c] |=> (host_rdata == $past(buf_flat[c*DW +: DW])));
    end
endmodule

// File: tb/tb_sampling_net_iface.sv
`timescale 1ns/1ps
module tb_sampling_net_iface;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0, host_re = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [37:0] tx_flit;
    logic        rx_valid = 1'b0;
    logic [33:0] rx_flit = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sampling_net_iface dut (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit),
        .rx_valid(rx_valid), .rx_flit(rx_flit)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [31:0] val;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd1, 32'hA5A5_0001},
        '{2'd3, 32'h1234_5678},
        '{2'd0, 32'hFFFF_FFFF},
        '{2'd1, 32'h0BAD_F00D},
        '{2'd2, 32'h0000_0001},
        '{2'd3, 32'h8000_0000},
        '{2'd2, 32'hCAFE_BEEF},
        '{2'd0, 32'h0000_0000}
    };

    logic [31:0] mdl [4];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        host_re = 1'b1; host_addr = a;
        @(negedge clk);
        host_re = 1'b0;
        d = host_rdata;
    endtask

    task automatic rx(input logic [1:0] ch, input logic [31:0] v);
        rx_valid = 1'b1; rx_flit = {ch, v};
        @(negedge clk);
        rx_valid = 1'b0;
        mdl[ch] = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 tx_valid", {63'd0, tx_valid}, 64'd0);
        rd(4'd2, r); chk("R1 status", {32'd0, r}, 64'd0);
        rd(4'd5, r); chk("R1 buffer", {32'd0, r}, 64'd0);

        // R2: one-cycle hold, header layout
        wr(4'd0, 32'h27);                 // router 2, interface 1, channel 3
        wr(4'd1, 32'hDEAD_0001);
        chk("R2 held, not yet sent", {63'd0, tx_valid}, 64'd0);
        // R4: second write while held is refused
        wr(4'd1, 32'h5555_5555);
        chk("R2 sent", {63'd0, tx_valid}, 64'd1);
        chk("R2 flit", {26'd0, tx_flit}, {26'd0, 2'b10, 2'b01, 2'b11, 32'hDEAD_0001});
        // R5: busy and overrun visible; R4: read clears overrun
        rd(4'd2, r); chk("R4 R5 status", {32'd0, r}, 64'h3);
        chk("R3 stalled flit", {26'd0, tx_flit}, {26'd0, 6'b100111, 32'hDEAD_0001});
        chk("R3 stalled valid", {63'd0, tx_valid}, 64'd1);
        rd(4'd2, r); chk("R4 overrun cleared", {32'd0, r}, 64'h2);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R3 dropped after accept", {63'd0, tx_valid}, 64'd0);
        rd(4'd2, r); chk("R5 idle status", {32'd0, r}, 64'd0);

        // R2: second destination, router ready throughout
        wr(4'd0, 32'h1C);                 // router 1, interface 3, channel 0
        tx_ready = 1'b1;
        wr(4'd1, 32'h0F0F_F0F0);
        chk("R2 hold with ready high", {63'd0, tx_valid}, 64'd0);
        @(negedge clk);
        chk("R2 sent 2", {63'd0, tx_valid}, 64'd1);
        chk("R2 flit 2", {26'd0, tx_flit}, {26'd0, 2'b01, 2'b11, 2'b00, 32'h0F0F_F0F0});
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R3 single transfer", {63'd0, tx_valid}, 64'd0);

        // R6 R7 R8: vector table walk
        for (int i = 0; i < 8; i++) begin
            rx(VECS[i].ch, VECS[i].val);
            rd(4'(4 + VECS[i].ch), r);
            chk("R6 R7 sample", {32'd0, r}, {32'd0, VECS[i].val});
            rd(4'(4 + VECS[i].ch), r);
            chk("R8 repeat read", {32'd0, r}, {32'd0, VECS[i].val});
        end
        for (int c = 0; c < 4; c++) begin
            rd(4'(4 + c), r);
            chk("R6 isolation", {32'd0, r}, {32'd0, mdl[c]});
        end

        // R9: arrival and read of the same channel in one cycle
        rx_valid = 1'b1; rx_flit = {2'd2, 32'h7777_0002};
        host_re = 1'b1; host_addr = 4'd6;
        @(negedge clk);
        rx_valid = 1'b0; host_re = 1'b0;
        chk("R9 collision returns old", {32'd0, host_rdata}, {32'd0, mdl[2]});
        mdl[2] = 32'h7777_0002;
        rd(4'd2, r); chk("R9 fresh kept", {63'd0, r[4]}, 64'd1);
        rd(4'd6, r); chk("R9 new sample", {32'd0, r}, {32'd0, mdl[2]});
        rd(4'd2, r); chk("R9 fresh cleared", {32'd0, r}, 64'd0);

        // R10: back-to-back arrivals alongside host writes
        host_we = 1'b1; host_addr = 4'd0; host_wdata = 32'h0;
        for (int c = 0; c < 4; c++) begin
            rx_valid = 1'b1; rx_flit = {2'(c), 32'h1000_0000 + c};
            mdl[c] = 32'h1000_0000 + c;
            @(negedge clk);
        end
        rx_valid = 1'b0; host_we = 1'b0;
        chk("R10 rdata unchanged without read", {32'd0, host_rdata}, 64'd0);
        rd(4'd2, r); chk("R10 R5 all fresh", {32'd0, r}, 64'h3C);
        for (int c = 0; c < 4; c++) begin
            rd(4'(4 + c), r);
            chk("R10 back-to-back", {32'd0, r}, {32'd0, mdl[c]});
        end
        rd(4'd3, r); chk("R10 unmapped", {32'd0, r}, 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule